// File: doc/BRIEF.md
# Zero-turnaround flow-through synchronous SRAM

This block models a synchronous static memory that takes a fresh read or write command on every rising clock edge. Switching between reading and writing costs no idle cycle. A write's data is sampled one enabled edge after its address. That delay lets a read issued on the next edge use the data bus while the write completes. Reads are flow-through: the registered address drives the array directly, and the word appears in the cycle that follows the capture edge.

Commands can be gated in several ways. Three synchronous chip selects qualify each new command. A clock enable freezes every internal register. A sleep input blocks all accesses. An asynchronous output enable gates the drivers. A load/advance control starts a four-beat burst, and the burst steps its two low address bits in linear or interleaved order. The data bus is brought out as three views: write data in, read data out, and a drive enable.

Top module: `ztsram`

## Requirements
- R1: After reset is released and before any command, `dqOe` is low and `dqOut` is zero.
- R2: A selected read captured on an enabled edge presents the addressed word on `dqOut` during the following cycle, and `dqOe` is high there unless `oeN` or `zz` is high.
- R3: Write data on `dqIn` is sampled on the enabled edge after the write's address edge. Lane i (bits 9i+8 down to 9i) is updated only when `bwN[i]` was low at the address edge.
- R4: Writes and reads may alternate on consecutive edges. A read issued on a write's data edge to the same address returns the new data.
- R5: A command is accepted only when `ce1N` is low, `ce2` is high and `ce3N` is low. Otherwise the array is unchanged and `dqOe` stays low in the next cycle.
- R6: During the cycle between a write's address edge and its data edge, `dqOe` is low whatever `oeN` does.
- R7: `oeN` high forces `dqOe` low without waiting for a clock edge. Lowering it re-enables the drive at once.
- R8: An edge with `cenN` high is ignored. All state holds, `dqOut` stays stable, and a pending write takes its data on the next enabled edge.
- R9: With `modeLinear` high at the load edge, advance cycles (`advLoad` high) access the base address with its low two bits replaced by (base + beat) mod 4. The upper bits are kept.
- R10: With `modeLinear` low at the load edge, the low two bits of each advance beat are the base's low bits XOR the beat number.
- R11: An enabled edge with `zz` high performs no access and drops any pending write. `dqOe` is low while `zz` is high.
- R12: An advance beat repeats the type (read or write) and selection outcome of the last load. Beats following a deselected load perform no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr | input | 6 | Word address for load cycles |
| advLoad | input | 1 | 1 = advance the current burst, 0 = load a new command |
| weN | input | 1 | Active-low write command on load cycles |
| bwN | input | 2 | Active-low byte-lane write selects |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| cenN | input | 1 | Active-low clock enable; high suspends the edge |
| modeLinear | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| zz | input | 1 | Sleep: blocks accesses and drive |
| oeN | input | 1 | Asynchronous active-low output enable |
| dqIn | input | 18 | Write data view of the bus |
| dqOut | output | 18 | Read data view of the bus |
| dqOe | output | 1 | Bus drive enable |

## Verification
The main function is exercised with four command patterns. Strict write/read alternation on one address shows whether the delayed write lands before the next read. Byte-lane masks on overwrite show whether each lane is written on its own. Linear and interleaved bursts from unaligned bases show whether the order mixes up wrap and XOR. Suspend and sleep cycles placed inside a write's data phase show whether the pending data edge is frozen or dropped as intended.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  parameter int ADDR_W = 6;
  parameter int LANES  = 2;
  parameter int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BEAT_W = 2;

  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic              wrEn;
    logic [LANES-1:0]  wrLanes;
    logic [ADDR_W-1:0] accAddr;
    logic              rdValid;
    logic              outEn;
  } strobe_t;
endpackage

// File: rtl/ztsram_ctrl.sv
module ztsram_ctrl
  import ztsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              advLoad,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              cenN,
  input  logic              modeLinear,
  input  logic              zz,
  output strobe_t           stb
);
  // burst state
  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic              burstSelQ;
  logic              burstWrQ;
  logic              burstLinQ;
  // command stage (address captured, data phase pending)
  logic              s1ValidQ;
  logic              s1WriteQ;
  logic [ADDR_W-1:0] s1AddrQ;
  logic [LANES-1:0]  s1LanesQ;

  logic              selected;
  logic [BEAT_W-1:0] beatNext;
  logic [BEAT_W-1:0] lowBits;
  logic [ADDR_W-1:0] advAddr;
  logic              cmdValid;
  logic              cmdWrite;
  logic [ADDR_W-1:0] cmdAddr;

  assign selected = !ce1N && ce2 && !ce3N;
  assign beatNext = beatQ + 1'b1;

  always_comb begin
    if (burstLinQ) lowBits = baseQ[BEAT_W-1:0] + beatNext;
    else           lowBits = baseQ[BEAT_W-1:0] ^ beatNext;
    advAddr = {baseQ[ADDR_W-1:BEAT_W], lowBits};
  end

  always_comb begin
    if (advLoad) begin
      cmdValid = burstSelQ;
      cmdWrite = burstWrQ;
      cmdAddr  = advAddr;
    end else begin
      cmdValid = selected;
      cmdWrite = !weN;
      cmdAddr  = addr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      beatQ     <= '0;
      burstSelQ <= 1'b0;
      burstWrQ  <= 1'b0;
      burstLinQ <= 1'b1;
      s1ValidQ  <= 1'b0;
      s1WriteQ  <= 1'b0;
      s1AddrQ   <= '0;
      s1LanesQ  <= '0;
    end else if (!cenN) begin
      if (zz) begin
        s1ValidQ <= 1'b0;
      end else begin
        s1ValidQ <= cmdValid;
        s1WriteQ <= cmdWrite;
        s1AddrQ  <= cmdAddr;
        s1LanesQ <= ~bwN;
        if (advLoad) begin
          beatQ <= beatNext;
        end else begin
          baseQ     <= addr;
          beatQ     <= '0;
          burstSelQ <= selected;
          burstWrQ  <= !weN;
          burstLinQ <= modeLinear;
        end
      end
    end
  end

  always_comb begin
    stb.wrEn    = !cenN && !zz && s1ValidQ && s1WriteQ;
    stb.wrLanes = s1LanesQ;
    stb.accAddr = s1AddrQ;
    stb.rdValid = s1ValidQ && !s1WriteQ;
    stb.outEn   = s1ValidQ && !s1WriteQ && !zz;
  end
endmodule

// File: rtl/ztsram_dp.sv
module ztsram_dp
  import ztsram_pkg::*;
(
  input  logic              clk,
  input  strobe_t           stb,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (stb.wrLanes[l])
          mem[stb.accAddr][l*LANE_W +: LANE_W] <= dqIn[l*LANE_W +: LANE_W];
      end
    end
  end

  assign dqOut = stb.rdValid ? mem[stb.accAddr] : '0;
  assign dqOe  = stb.outEn && !oeN;
endmodule

// File: rtl/ztsram.sv
module ztsram
  import ztsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              advLoad,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              cenN,
  input  logic              modeLinear,
  input  logic              zz,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  strobe_t stb;

  ztsram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .advLoad(advLoad), .weN(weN),
    .bwN(bwN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .cenN(cenN),
    .modeLinear(modeLinear), .zz(zz), .stb(stb)
  );

  ztsram_dp u_dp (
    .clk(clk), .stb(stb), .oeN(oeN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: rtl/ztsram_chk.sv
module ztsram_chk
  import ztsram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              advLoad,
  input logic              weN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              cenN,
  input logic              zz,
  input logic              oeN,
  input logic [DATA_W-1:0] dqOut,
  input logic              dqOe
);
  logic sel;
  assign sel = !ce1N && ce2 && !ce3N;

  AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !zz && !advLoad && sel && !weN) |=> !dqOe); // R6
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !advLoad && !sel) |=> !dqOe); // R5
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    zz |-> !dqOe); // R11
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> $stable(dqOut)); // R8
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !zz && !advLoad && sel && weN) |=> (oeN || zz || dqOe)); // R2
endmodule

bind ztsram ztsram_chk u_chk (
  .clk(clk), .rstN(rstN), .advLoad(advLoad), .weN(weN), .ce1N(ce1N),
  .ce2(ce2), .ce3N(ce3N), .cenN(cenN), .zz(zz), .oeN(oeN),
  .dqOut(dqOut), .dqOe(dqOe)
);

// File: tb/ztsram_bench.sv
module ztsram_bench;
  import ztsram_pkg::*;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              advLoad = 1'b0;
  logic              weN = 1'b1;
  logic [LANES-1:0]  bwN = '1;
  logic              ce1N = 1'b1;
  logic              ce2 = 1'b1;
  logic              ce3N = 1'b0;
  logic              cenN = 1'b0;
  logic              modeLinear = 1'b1;
  logic              zz = 1'b0;
  logic              oeN = 1'b0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ztsram u_ztsram (
    .clk(clk), .rstN(rstN), .addr(addr), .advLoad(advLoad), .weN(weN),
    .bwN(bwN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .cenN(cenN),
    .modeLinear(modeLinear), .zz(zz), .oeN(oeN), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                     input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sel: 0 all selects active, 1 ce1N off, 2 ce2 off, 3 ce3N off
  task automatic cyc(input logic adv, input logic wr, input logic [LANES-1:0] lanes,
                     input int sel, input logic cen, input logic slp, input logic lin,
                     input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    advLoad = adv; weN = !wr; bwN = ~lanes;
    ce1N = (sel == 1); ce2 = (sel != 2); ce3N = (sel == 3);
    cenN = cen; zz = slp; modeLinear = lin; addr = a; dqIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [DATA_W-1:0] d);
    cyc(1'b0, 1'b0, '1, 1, 1'b0, 1'b0, 1'b1, '0, d);
  endtask
  task automatic wrC(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] lanes,
                     input logic [DATA_W-1:0] d);
    cyc(1'b0, 1'b1, lanes, 0, 1'b0, 1'b0, 1'b1, a, d);
  endtask
  task automatic rdC(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cyc(1'b0, 1'b0, '1, 0, 1'b0, 1'b0, 1'b1, a, d);
  endtask
  task automatic fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
    wrC(a, '1, '0);
    idle(v);
  endtask

  task automatic t_reset();
    chk(DATA_W'(dqOe), '0, "R1 oe after reset");
    chk(dqOut, '0, "R1 data after reset");
  endtask

  task automatic t_alternate();
    wrC(6'd5, '1, '0);
    chk(DATA_W'(dqOe), '0, "R6 no drive in write data phase");
    rdC(6'd5, 18'h2A5A5);
    chk(dqOut, 18'h2A5A5, "R4 read right after write");
    chk(DATA_W'(dqOe), 18'd1, "R2 read drives");
    wrC(6'd6, '1, '0);
    rdC(6'd6, 18'h13C3C);
    chk(dqOut, 18'h13C3C, "R4 second alternation");
    rdC(6'd5, '0);
    chk(dqOut, 18'h2A5A5, "R2 flow-through read");
  endtask

  task automatic t_lanes();
    fill(6'd7, 18'h3FE01);
    wrC(6'd7, 2'b01, '0);
    idle(18'h00155);
    rdC(6'd7, '0);
    chk(dqOut, 18'h3FF55, "R3 lane0 only");
    wrC(6'd7, 2'b10, '0);
    idle(18'h2AA00);
    rdC(6'd7, '0);
    chk(dqOut, 18'h2AB55, "R3 lane1 only");
  endtask

  task automatic t_select();
    fill(6'd8, 18'h11111);
    for (int s = 1; s < 4; s++) begin
      cyc(1'b0, 1'b1, '1, s, 1'b0, 1'b0, 1'b1, 6'd8, '0);
      idle(18'h22222);
    end
    cyc(1'b0, 1'b0, '1, 2, 1'b0, 1'b0, 1'b1, 6'd8, '0);
    chk(DATA_W'(dqOe), '0, "R5 deselected read no drive");
    rdC(6'd8, '0);
    chk(dqOut, 18'h11111, "R5 deselected writes ignored");
  endtask

  task automatic t_oe();
    oeN = 1'b1;
    rdC(6'd5, '0);
    chk(DATA_W'(dqOe), '0, "R7 oeN high blocks drive");
    chk(dqOut, 18'h2A5A5, "R7 data still read");
    oeN = 1'b0;
    #1;
    chk(DATA_W'(dqOe), 18'd1, "R7 drive returns at once");
  endtask

  task automatic t_suspend();
    rdC(6'd5, '0);
    cyc(1'b0, 1'b1, '1, 0, 1'b1, 1'b0, 1'b1, 6'd6, '0);
    chk(dqOut, 18'h2A5A5, "R8 output holds in suspend");
    wrC(6'd9, '1, '0);
    cyc(1'b0, 1'b0, '1, 0, 1'b1, 1'b0, 1'b1, 6'd6, 18'h3DEAD);
    rdC(6'd9, 18'h0BEEF);
    chk(dqOut, 18'h0BEEF, "R8 write data taken after suspend");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) fill(6'(16 + i), 18'(18'h01600 + i));
    // linear from base 18: 18,19,16,17, then wraps to 18
    cyc(1'b0, 1'b0, '1, 0, 1'b0, 1'b0, 1'b1, 6'd18, '0);
    chk(dqOut, 18'h01602, "R9 linear beat0");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(dqOut, 18'h01603, "R9 linear beat1");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(dqOut, 18'h01600, "R9 linear beat2 wraps");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(dqOut, 18'h01601, "R9 linear beat3");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(dqOut, 18'h01602, "R9 linear fifth beat");
    // interleaved from base 17: 17,16,19,18
    cyc(1'b0, 1'b0, '1, 0, 1'b0, 1'b0, 1'b0, 6'd17, '0);
    chk(dqOut, 18'h01601, "R10 interleaved beat0");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b1, '0, '0);
    chk(dqOut, 18'h01600, "R10 interleaved beat1");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b1, '0, '0);
    chk(dqOut, 18'h01603, "R10 interleaved beat2");
    cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b1, '0, '0);
    chk(dqOut, 18'h01602, "R10 interleaved beat3");
  endtask

  task automatic t_burst_write();
    cyc(1'b0, 1'b1, '1, 0, 1'b0, 1'b0, 1'b1, 6'd20, '0);
    for (int i = 0; i < 3; i++)
      cyc(1'b1, 1'b0, '1, 1, 1'b0, 1'b0, 1'b1, '0, 18'(18'h02000 + i));
    idle(18'h02003);
    for (int i = 0; i < 4; i++) begin
      rdC(6'(20 + i), '0);
      chk(dqOut, 18'(18'h02000 + i), "R12 burst write beats");
    end
    cyc(1'b0, 1'b0, '1, 3, 1'b0, 1'b0, 1'b1, 6'd20, '0);
    cyc(1'b1, 1'b0, '1, 0, 1'b0, 1'b0, 1'b1, '0, '0);
    chk(DATA_W'(dqOe), '0, "R12 advance after deselected load");
  endtask

  task automatic t_sleep();
    fill(6'd10, 18'h0A0A0);
    cyc(1'b0, 1'b1, '1, 0, 1'b0, 1'b1, 1'b1, 6'd10, '0);
    rdC(6'd10, 18'h3FFFF);
    chk(dqOut, 18'h0A0A0, "R11 write in sleep ignored");
    wrC(6'd10, '1, '0);
    cyc(1'b0, 1'b0, '1, 0, 1'b0, 1'b1, 1'b1, 6'd10, 18'h15555);
    chk(DATA_W'(dqOe), '0, "R11 no drive in sleep");
    rdC(6'd10, '0);
    chk(dqOut, 18'h0A0A0, "R11 pending write dropped");
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_alternate();
    t_lanes();
    t_select();
    t_oe();
    t_suspend();
    t_burst();
    t_burst_write();
    t_sleep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule